// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact processor that completes one instruction in each clock cycle. The program counter selects a word from a small local instruction store. The word is split into fields using one of three fixed layouts: register, immediate or jump. Two of the 32 general registers are read. The core then performs an arithmetic or logic operation, a word load, or a word store. On the next rising edge it writes at most one register and loads the program counter with its successor. Successors include relative branches, absolute jumps, a call that saves its return address in register 31, and a return through a register.

Both local stores can be reached from outside through simple ports. A program is written into instruction words while reset is held. Data words can be preloaded and read back at any time. Any register can be read through a peek port. The program counter is also brought out. Reset is synchronous and returns the program counter to zero. While reset is asserted, the core changes neither registers nor data memory.

Top module: `sc_int_core`

## Requirements
- R1: With `rst` high at a rising edge, `pc_out` becomes 0 and the core writes no register and no data word. The load ports still work during reset.
- R2: Register 0 always reads as zero through every path, including the peek port. Any write aimed at register 0 is discarded.
- R3: Opcode 000000 selects a register operation by its low six bits (funct), and the result goes to rd. The funct codes are: add 100000, sub 100010, and 100100, or 100101, slt 101010 (1 if rs < rt as signed values, else 0), sll 000000 and srl 000010. The two shifts move rt by the shamt field (bits 10:6); srl fills with zeros.
- R4: Three immediate operations write rt. Opcode 001000 adds rs to the sign-extended immediate. Opcode 001101 ORs rs with the zero-extended immediate. Opcode 001111 places the immediate in bits 31:16 and clears bits 15:0.
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended immediate into rt. Opcode 101011 stores rt to that address. The word index is address bits [DAW+1:2].
- R6: Opcode 000100 (equal) and opcode 000101 (not equal) compare rs with rt. When the branch is taken, PC becomes PC+4 plus the sign-extended immediate shifted left by 2. Otherwise PC becomes PC+4.
- R7: Opcode 000010 jumps to {PC+4 bits 31:28, target(26), 00}. Opcode 000011 makes the same jump and also writes PC+4 into register 31.
- R8: Opcode 000000 with funct 001000 loads PC from rs and writes no register, whatever the rd field holds.
- R9: Every instruction that is not a branch or jump advances PC by 4. An unsupported opcode, or an unsupported funct under opcode 000000, writes nothing.
- R10: Instruction words are written through `imem_we`/`imem_addr`/`imem_wdata` on a rising edge. Data words are preloaded through `dmem_ld_*`, and the port reads back combinationally. Registers are read through `reg_peek_*`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset |
| imem_we | input | 1 | Instruction word write enable |
| imem_addr | input | IAW | Instruction word index |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_ld_we | input | 1 | Data word preload enable |
| dmem_ld_addr | input | DAW | Data word index for preload/readback |
| dmem_ld_wdata | input | 32 | Data word to preload |
| dmem_ld_rdata | output | 32 | Data word readback |
| reg_peek_addr | input | 5 | Register to observe |
| reg_peek_data | output | 32 | Observed register value |
| pc_out | output | 32 | Current program counter |

## Verification
The arithmetic sweep pairs operands at the signed and unsigned extremes. A design that compares slt without sign would rank 0x80000000 above 1, and an arithmetic srl would drag ones down from bit 31. A negative immediate catches an ori that sign-extends, or an addi that zero-extends. The branch program runs a backward loop and forward skips, so an offset taken from PC instead of PC+4, or an unshifted offset, lands on the wrong word and shows up as a wrong loop count or a skipped write. The remaining checks cover a call and return, a store while reset is held, a write to register 0, and undecodable words. Each one would expose a link in the wrong register, a corrupted word, a non-zero register 0, or a stray write.

// File: rtl/sc_int_core.sv
module sc_int_core #(
  parameter int IAW = 6,
  parameter int DAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [IAW-1:0] imem_addr,
  input  logic [31:0]    imem_wdata,
  input  logic           dmem_ld_we,
  input  logic [DAW-1:0] dmem_ld_addr,
  input  logic [31:0]    dmem_ld_wdata,
  output logic [31:0]    dmem_ld_rdata,
  input  logic [4:0]     reg_peek_addr,
  output logic [31:0]    reg_peek_data,
  output logic [31:0]    pc_out
);
  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_J    = 6'b000010;
  localparam logic [5:0] OP_JAL  = 6'b000011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_BNE  = 6'b000101;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_LUI  = 6'b001111;
  localparam logic [5:0] OP_LW   = 6'b100011;
  localparam logic [5:0] OP_SW   = 6'b101011;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  logic [31:0] imem [IDEPTH];
  logic [31:0] dmem [DDEPTH];
  logic [31:0] rf   [32];
  logic [31:0] pc;

  logic [31:0] instr;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, sh;
  logic [15:0] imm;
  logic [31:0] sext, zext, pc4, br_tgt, j_tgt, ea;
  logic [31:0] rs_val, rt_val, ld_val;
  logic [DAW-1:0] didx;

  logic        rf_we, dm_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, npc;

  assign instr  = imem[pc[IAW+1:2]];
  assign op     = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign sh     = instr[10:6];
  assign fn     = instr[5:0];
  assign imm    = instr[15:0];
  assign sext   = {{16{imm[15]}}, imm};
  assign zext   = {16'h0000, imm};
  assign pc4    = pc + 32'd4;
  assign br_tgt = pc4 + {sext[29:0], 2'b00};
  assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign ea     = rs_val + sext;
  assign didx   = ea[DAW+1:2];
  assign ld_val = dmem[didx];

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rt;
    rf_wdata = 32'd0;
    dm_we    = 1'b0;
    npc      = pc4;
    unique case (op)
      OP_REG: begin
        rf_waddr = rd;
        rf_we    = 1'b1;
        case (fn)
          FN_ADD: rf_wdata = rs_val + rt_val;
          FN_SUB: rf_wdata = rs_val - rt_val;
          FN_AND: rf_wdata = rs_val & rt_val;
          FN_OR:  rf_wdata = rs_val | rt_val;
          FN_SLT: rf_wdata = {31'd0, $signed(rs_val) < $signed(rt_val)};
          FN_SLL: rf_wdata = rt_val << sh;
          FN_SRL: rf_wdata = rt_val >> sh;
          FN_JR: begin
            rf_we = 1'b0;
            npc   = rs_val;
          end
          default: rf_we = 1'b0;
        endcase
      end
      OP_ADDI: begin rf_we = 1'b1; rf_wdata = rs_val + sext; end
      OP_ORI:  begin rf_we = 1'b1; rf_wdata = rs_val | zext; end
      OP_LUI:  begin rf_we = 1'b1; rf_wdata = {imm, 16'h0000}; end
      OP_LW:   begin rf_we = 1'b1; rf_wdata = ld_val; end
      OP_SW:   dm_we = 1'b1;
      OP_BEQ:  if (rs_val == rt_val) npc = br_tgt;
      OP_BNE:  if (rs_val != rt_val) npc = br_tgt;
      OP_J:    npc = j_tgt;
      OP_JAL: begin
        rf_we    = 1'b1;
        rf_waddr = 5'd31;
        rf_wdata = pc4;
        npc      = j_tgt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= npc;
  end

  always_ff @(posedge clk) begin
    if (!rst && rf_we && rf_waddr != 5'd0) rf[rf_waddr] <= rf_wdata;
  end

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst && dm_we) dmem[didx] <= rt_val;
    else if (dmem_ld_we) dmem[dmem_ld_addr] <= dmem_ld_wdata;
  end

  assign dmem_ld_rdata = dmem[dmem_ld_addr];
  assign reg_peek_data = (reg_peek_addr == 5'd0) ? 32'd0 : rf[reg_peek_addr];
  assign pc_out        = pc;
endmodule

// File: rtl/sc_int_core_chk.sv
module sc_int_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic        rf_we,
  input logic [4:0]  rf_waddr
);
  logic [5:0]  op;
  logic [5:0]  fn;
  logic [31:0] boff;
  logic        straight;

  assign op   = instr[31:26];
  assign fn   = instr[5:0];
  assign boff = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign straight = !(op == 6'b000100 || op == 6'b000101 || op == 6'b000010 ||
                      op == 6'b000011 || (op == 6'b000000 && fn == 6'b001000));

  a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
    instr[25:21] == 5'd0 |-> rs_val == 32'd0);

  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    straight |=> pc == $past(pc) + 32'd4);

  a_r6_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000100 && instr[25:21] == instr[20:16]) |=> pc == $past(pc) + 32'd4 + $past(boff));

  a_r7_link: assert property (@(posedge clk) disable iff (rst)
    op == 6'b000011 |-> rf_we && rf_waddr == 5'd31);

  a_r8_jr_nowrite: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000000 && fn == 6'b001000) |-> !rf_we);

  a_r8_jr_target: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000000 && fn == 6'b001000) |=> pc == $past(rs_val));
endmodule

bind sc_int_core sc_int_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .rs_val(rs_val), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/sc_int_core_bench.sv
module sc_int_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_addr = '0;
  logic [31:0] imem_wdata = '0;
  logic        dmem_ld_we = 1'b0;
  logic [5:0]  dmem_ld_addr = '0;
  logic [31:0] dmem_ld_wdata = '0;
  logic [31:0] dmem_ld_rdata;
  logic [4:0]  reg_peek_addr = '0;
  logic [31:0] reg_peek_data;
  logic [31:0] pc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] prog [64];

  always #5 clk = ~clk;

  sc_int_core u_sc_int_core (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr),
    .dmem_ld_wdata(dmem_ld_wdata), .dmem_ld_rdata(dmem_ld_rdata),
    .reg_peek_addr(reg_peek_addr), .reg_peek_data(reg_peek_data),
    .pc_out(pc_out)
  );

  function automatic logic [31:0] e_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                      logic [4:0] sh, logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] e_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                      logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] e_j(logic [5:0] op, logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    reg_peek_addr = r;
    #1 v = reg_peek_data;
  endtask

  task automatic chk_reg(string req, logic [4:0] r, logic [31:0] exp);
    logic [31:0] v;
    peek(r, v);
    chk(req, v, exp);
  endtask

  task automatic chk_mem(string req, logic [5:0] a, logic [31:0] exp);
    dmem_ld_addr = a;
    #1 chk(req, dmem_ld_rdata, exp);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
  endtask

  task automatic load_prog();
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = i[5:0]; imem_wdata = prog[i];
    end
    @(negedge clk) imem_we = 1'b0;
  endtask

  task automatic run(int n);
    @(negedge clk) rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] vals [6];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7fff_ffff;
    vals[3] = 32'h8000_0000; vals[4] = 32'hffff_ffff; vals[5] = 32'h1234_5678;

    clear_prog();
    prog[0] = e_j(6'b000010, 26'd0);
    load_prog();
    chk("R1 pc in reset", pc_out, 32'd0);

    // R3 R4: operand sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a, b, se;
        logic [4:0]  k;
        logic [15:0] im;
        a = vals[i]; b = vals[j];
        k = 5'((i * 5 + j * 7) % 32);
        im = 16'h8000 ^ 16'(i * 4369 + j * 257);
        se = {{16{im[15]}}, im};
        clear_prog();
        prog[0]  = e_i(6'b001111, 0, 1, a[31:16]);
        prog[1]  = e_i(6'b001101, 1, 1, a[15:0]);
        prog[2]  = e_i(6'b001111, 0, 2, b[31:16]);
        prog[3]  = e_i(6'b001101, 2, 2, b[15:0]);
        prog[4]  = e_r(1, 2, 3, 0, 6'b100000);
        prog[5]  = e_r(1, 2, 4, 0, 6'b100010);
        prog[6]  = e_r(1, 2, 5, 0, 6'b100100);
        prog[7]  = e_r(1, 2, 6, 0, 6'b100101);
        prog[8]  = e_r(1, 2, 7, 0, 6'b101010);
        prog[9]  = e_r(0, 2, 8, k, 6'b000000);
        prog[10] = e_r(0, 2, 9, k, 6'b000010);
        prog[11] = e_i(6'b001000, 1, 10, im);
        prog[12] = e_i(6'b001101, 1, 11, im);
        prog[13] = e_i(6'b001111, 0, 12, im);
        prog[14] = e_j(6'b000010, 26'd14);
        load_prog();
        run(20);
        chk_reg("R3 add", 3, a + b);
        chk_reg("R3 sub", 4, a - b);
        chk_reg("R3 and", 5, a & b);
        chk_reg("R3 or", 6, a | b);
        chk_reg("R3 slt", 7, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        chk_reg("R3 sll", 8, b << k);
        chk_reg("R3 srl", 9, b >> k);
        chk_reg("R4 addi", 10, a + se);
        chk_reg("R4 ori", 11, a | {16'h0, im});
        chk_reg("R4 lui", 12, {im, 16'h0});
      end
    end

    // R2: register zero
    clear_prog();
    prog[0] = e_i(6'b001000, 0, 0, 16'd5);
    prog[1] = e_r(0, 0, 12, 0, 6'b100000);
    prog[2] = e_i(6'b001101, 0, 13, 16'hffff);
    prog[3] = e_j(6'b000010, 26'd3);
    load_prog();
    run(8);
    chk_reg("R2 r0 peek", 0, 32'd0);
    chk_reg("R2 r0 read", 12, 32'd0);
    chk_reg("R4 ori zero-ext", 13, 32'h0000_ffff);

    // R1: store held off in reset, then R5 store after release
    clear_prog();
    prog[0] = e_i(6'b101011, 0, 0, 16'd0);
    prog[1] = e_j(6'b000010, 26'd1);
    load_prog();
    @(negedge clk) begin dmem_ld_we = 1'b1; dmem_ld_addr = 6'd0; dmem_ld_wdata = 32'h55; end
    @(negedge clk) dmem_ld_we = 1'b0;
    repeat (4) @(negedge clk);
    chk_mem("R1 no store in reset", 6'd0, 32'h55);
    chk_mem("R10 preload readback", 6'd0, 32'h55);
    run(3);
    chk_mem("R5 store r0", 6'd0, 32'd0);

    // R5: loads and stores
    clear_prog();
    prog[0] = e_i(6'b001000, 0, 1, 16'd8);
    prog[1] = e_i(6'b100011, 1, 2, 16'd12);
    prog[2] = e_i(6'b001000, 0, 3, 16'hffff);
    prog[3] = e_i(6'b101011, 1, 3, 16'hfffc);
    prog[4] = e_i(6'b101011, 1, 2, 16'd32);
    prog[5] = e_i(6'b100011, 0, 4, 16'd4);
    prog[6] = e_j(6'b000010, 26'd6);
    load_prog();
    @(negedge clk) begin dmem_ld_we = 1'b1; dmem_ld_addr = 6'd5; dmem_ld_wdata = 32'hcafe_f00d; end
    @(negedge clk) dmem_ld_we = 1'b0;
    run(10);
    chk_reg("R5 lw offset", 2, 32'hcafe_f00d);
    chk_reg("R4 addi negative", 3, 32'hffff_ffff);
    chk_reg("R5 lw after sw", 4, 32'hffff_ffff);
    chk_mem("R5 sw negative offset", 6'd1, 32'hffff_ffff);
    chk_mem("R5 sw positive offset", 6'd10, 32'hcafe_f00d);
    chk_mem("R5 loaded word kept", 6'd5, 32'hcafe_f00d);

    // R6: branches
    clear_prog();
    prog[0]  = e_i(6'b001000, 0, 5, 16'd3);
    prog[1]  = e_i(6'b001000, 0, 1, 16'd0);
    prog[2]  = e_i(6'b001000, 0, 2, 16'd5);
    prog[3]  = e_i(6'b001000, 1, 1, 16'd1);
    prog[4]  = e_i(6'b000101, 1, 2, 16'hfffe);
    prog[5]  = e_i(6'b000100, 1, 2, 16'd1);
    prog[6]  = e_i(6'b001000, 0, 5, 16'd99);
    prog[7]  = e_i(6'b000100, 1, 0, 16'd1);
    prog[8]  = e_i(6'b001000, 0, 6, 16'd7);
    prog[9]  = e_i(6'b000101, 1, 1, 16'd1);
    prog[10] = e_i(6'b001000, 0, 7, 16'd9);
    prog[11] = e_j(6'b000010, 26'd11);
    load_prog();
    run(40);
    chk_reg("R6 bne loop count", 1, 32'd5);
    chk_reg("R6 beq taken skip", 5, 32'd3);
    chk_reg("R6 beq not taken", 6, 32'd7);
    chk_reg("R6 bne not taken", 7, 32'd9);
    chk("R7 j self holds pc", pc_out, 32'd44);

    // R7 R8 R9: call, return, unsupported words
    clear_prog();
    prog[0]  = e_i(6'b001000, 0, 22, 16'd4);
    prog[1]  = e_j(6'b000011, 26'd8);
    prog[2]  = e_i(6'b001000, 0, 21, 16'd21);
    prog[3]  = e_j(6'b000010, 26'd12);
    prog[4]  = e_i(6'b001000, 0, 22, 16'd1);
    prog[8]  = e_i(6'b001000, 0, 23, 16'd23);
    prog[9]  = e_i(6'b001000, 0, 20, 16'd20);
    prog[10] = e_r(31, 0, 23, 0, 6'b001000);
    prog[12] = e_i(6'b001000, 0, 24, 16'd24);
    prog[13] = e_i(6'b001000, 0, 25, 16'd25);
    prog[14] = e_i(6'b111111, 0, 24, 16'h1234);
    prog[15] = e_r(1, 2, 25, 0, 6'b111111);
    prog[16] = e_i(6'b001000, 0, 26, 16'd26);
    prog[17] = e_j(6'b000010, 26'd17);
    load_prog();
    run(30);
    chk_reg("R7 jal link", 31, 32'd8);
    chk_reg("R7 jal target body", 20, 32'd20);
    chk_reg("R8 jr returns", 21, 32'd21);
    chk_reg("R7 j skips", 22, 32'd4);
    chk_reg("R8 jr no rd write", 23, 32'd23);
    chk_reg("R9 bad opcode no write", 24, 32'd24);
    chk_reg("R9 bad funct no write", 25, 32'd25);
    chk_reg("R9 advance past bad words", 26, 32'd26);
    chk("R9 final pc", pc_out, 32'd68);

    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R1 reset returns pc", pc_out, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule